// File: doc/BRIEF.md
# USB OTG Session Request Sequencer

This block lets a self-powered USB B-device ask an A-device to power the bus and open a session. After a start strobe it checks the initial-condition status. It then drives a timed D+ pulse, followed by a timed VBUS pulse. An optional VBUS discharge interval comes next. Last, it watches the B-session-valid comparator until a timeout. It ends each request with a one-cycle result flag, marked either success or failure.

All intervals are whole milliseconds. A prescaler derived from the clock-frequency parameter produces the millisecond ticks. The prescaler restarts at every phase change, so each phase lasts exactly its programmed number of milliseconds. A deadline counter runs through the two pulsing phases. A low OTG-enable forces every drive output low and aborts any request in progress. The analog drivers and comparators sit outside the block.

Top module: `srp_sequencer`

## Requirements
- R1: A start strobe in idle with `init_ok`=1 makes `dp_pulse` rise on the next cycle. With `init_ok`=0, the block instead raises `done` and `fail` for one cycle on the next cycle and drives no pulse. A start outside idle is ignored.
- R2: `dp_pulse` stays high for exactly DP_MS milliseconds, which is DP_MS*CLK_HZ/1000 cycles. DP_MS must lie in 5..10.
- R3: `vbus_pulse` rises in the cycle after `dp_pulse` falls and stays high for exactly VP_MS milliseconds. VP_MS must lie in 17..25.
- R4: If LIMIT_MS milliseconds pass from the first D+ pulse cycle before the VBUS pulse has ended, the block drops its pulse and raises `done`+`fail`. If the VBUS pulse ends in the same tick as the deadline, the pulse counts as completed in time.
- R5: If `disch_en` is 1 in the cycle the VBUS pulse ends, `vbus_disch` is high for exactly DIS_MS milliseconds right after it. Otherwise detection starts at once. `vbus_disch` is always low during detection.
- R6: `bsess_valid` is only judged in the detection phase. If it is high there, the next cycle shows `done`+`ok`. A high `bsess_valid` during the pulsing phases has no effect.
- R7: If `bsess_valid` stays low for DET_MS milliseconds of detection, the block raises `done`+`fail`. Each result flag lasts one cycle, and the block is idle in that cycle.
- R8: `vbus_irq` has no effect. Both pulse lengths and the result are unchanged when it is high throughout.
- R9: When `otg_en`=0, all six outputs are low in that same cycle and the sequencer returns to idle. Raising `otg_en` again does not resume the aborted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| otg_en | input | 1 | Enables the sequencer; low masks outputs and aborts |
| start | input | 1 | One-cycle request strobe |
| init_ok | input | 1 | Initial line and bus conditions are met |
| disch_en | input | 1 | Run the VBUS discharge phase |
| bsess_valid | input | 1 | B-session-valid comparator |
| vbus_irq | input | 1 | VBUS interrupt status, ignored |
| dp_pulse | output | 1 | D+ pulse drive |
| vbus_pulse | output | 1 | VBUS pulse drive |
| vbus_disch | output | 1 | VBUS discharge drive |
| done | output | 1 | One-cycle end-of-request flag |
| ok | output | 1 | With done: session detected |
| fail | output | 1 | With done: request failed |

## Verification
The deadline expiry and the end of the VBUS pulse can land on the same millisecond tick. In that case the phase ending must win over the failure. A second instance has its deadline set to exactly the sum of the two pulse lengths, and a third has a shorter deadline. All three instances get the same stimulus. The bench judges them against behavioural reference models running alongside: the tied instance must report success, and the short one must report failure at the deadline cycle.

// File: rtl/srp_pkg.sv
package srp_pkg;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_DPULSE = 3'd1,
      S_VPULSE = 3'd2,
      S_DISCH  = 3'd3,
      S_DETECT = 3'd4
   } srp_state_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/srp_tick.sv
module srp_tick #(
   parameter int DIV = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;

         assign tick = (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt <= '0;
            else if (restart || tick) cnt <= '0;
            else                      cnt <= cnt + 1'b1;
         end

         // ticks are at least two cycles apart when the divider exceeds one
         assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
   import srp_pkg::*;
#(
   parameter int DP_MS    = 7,
   parameter int VP_MS    = 20,
   parameter int DIS_MS   = 30,
   parameter int DET_MS   = 100,
   parameter int LIMIT_MS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic otg_en,
   input  logic start,
   input  logic init_ok,
   input  logic disch_en,
   input  logic bsess_valid,
   input  logic vbus_irq,
   input  logic tick,
   output logic restart,
   output logic dp_on,
   output logic vp_on,
   output logic dis_on,
   output logic done_q,
   output logic ok_q,
   output logic fail_q
);

   localparam int PH_MAX = max2(max2(DP_MS, VP_MS), max2(DIS_MS, DET_MS));
   localparam int PW     = $clog2(PH_MAX + 1);
   localparam int TW     = $clog2(LIMIT_MS + 1);
   localparam logic [PW-1:0] DP_LAST  = PW'(DP_MS - 1);
   localparam logic [PW-1:0] VP_LAST  = PW'(VP_MS - 1);
   localparam logic [PW-1:0] DIS_LAST = PW'(DIS_MS - 1);
   localparam logic [PW-1:0] DET_LAST = PW'(DET_MS - 1);
   localparam logic [TW-1:0] LIM_LAST = TW'(LIMIT_MS - 1);

   srp_state_t    st, st_nx;
   logic [PW-1:0] ph_ms;
   logic [TW-1:0] tot_ms;
   logic          fin, fin_ok;
   logic          deadline;

   assign deadline = tick && (tot_ms == LIM_LAST);

   always_comb begin
      st_nx  = st;
      fin    = 1'b0;
      fin_ok = 1'b0;
      if (!otg_en) begin
         st_nx = S_IDLE;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  if (init_ok) st_nx = S_DPULSE;
                  else         fin   = 1'b1;
               end
            end
            S_DPULSE: begin
               if (tick && ph_ms == DP_LAST) begin
                  st_nx = S_VPULSE;
               end else if (deadline) begin
                  st_nx = S_IDLE;
                  fin   = 1'b1;
               end
            end
            S_VPULSE: begin
               if (tick && ph_ms == VP_LAST) begin
                  st_nx = disch_en ? S_DISCH : S_DETECT;
               end else if (deadline) begin
                  st_nx = S_IDLE;
                  fin   = 1'b1;
               end
            end
            S_DISCH: begin
               if (tick && ph_ms == DIS_LAST) st_nx = S_DETECT;
            end
            S_DETECT: begin
               if (bsess_valid) begin
                  st_nx  = S_IDLE;
                  fin    = 1'b1;
                  fin_ok = 1'b1;
               end else if (tick && ph_ms == DET_LAST) begin
                  st_nx = S_IDLE;
                  fin   = 1'b1;
               end
            end
            default: st_nx = S_IDLE;
         endcase
      end
   end

   assign restart = (st_nx != st) || (st == S_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ph_ms  <= '0;
         tot_ms <= '0;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         st     <= st_nx;
         done_q <= fin;
         ok_q   <= fin_ok;
         fail_q <= fin && !fin_ok;
         if (restart)   ph_ms <= '0;
         else if (tick) ph_ms <= ph_ms + 1'b1;
         if (st == S_IDLE)
            tot_ms <= '0;
         else if (tick && (st == S_DPULSE || st == S_VPULSE))
            tot_ms <= tot_ms + 1'b1;
      end
   end

   assign dp_on  = otg_en && (st == S_DPULSE);
   assign vp_on  = otg_en && (st == S_VPULSE);
   assign dis_on = otg_en && (st == S_DISCH);

   assert_dp_needs_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dp_on) |-> $past(start && init_ok));

   assert_vp_after_dp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vp_on) |-> $past(dp_on));

   assert_disch_after_vp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_on) |-> $past(vp_on));

   assert_ok_from_detect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ok_q |-> $past(st == S_DETECT && bsess_valid));

   assert_idle_on_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (st == S_IDLE));

   assert_irq_no_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (otg_en && vbus_irq && !tick && st == S_DPULSE) |=> (st == S_DPULSE));

   assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !otg_en |=> (st == S_IDLE));

endmodule

// File: rtl/srp_sequencer.sv
module srp_sequencer #(
   parameter int CLK_HZ   = 48_000_000,
   parameter int DP_MS    = 7,
   parameter int VP_MS    = 20,
   parameter int DIS_MS   = 30,
   parameter int DET_MS   = 100,
   parameter int LIMIT_MS = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic otg_en,
   input  logic start,
   input  logic init_ok,
   input  logic disch_en,
   input  logic bsess_valid,
   input  logic vbus_irq,
   output logic dp_pulse,
   output logic vbus_pulse,
   output logic vbus_disch,
   output logic done,
   output logic ok,
   output logic fail
);

   localparam int DIV = CLK_HZ / 1000;

   generate
      if (CLK_HZ < 1000 || (CLK_HZ % 1000) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a whole multiple of 1000");
      end
      if (DP_MS < 5 || DP_MS > 10) begin : g_bad_dp
         $error("DP_MS must lie in 5..10");
      end
      if (VP_MS < 17 || VP_MS > 25) begin : g_bad_vp
         $error("VP_MS must lie in 17..25");
      end
      if (DIS_MS < 1 || DET_MS < 1) begin : g_bad_len
         $error("DIS_MS and DET_MS must be at least 1");
      end
      if (LIMIT_MS < 1 || LIMIT_MS > 100) begin : g_bad_lim
         $error("LIMIT_MS must lie in 1..100");
      end
   endgenerate

   logic tick, restart;
   logic done_q, ok_q, fail_q;

   srp_tick #(.DIV(DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   srp_ctrl #(
      .DP_MS    (DP_MS),
      .VP_MS    (VP_MS),
      .DIS_MS   (DIS_MS),
      .DET_MS   (DET_MS),
      .LIMIT_MS (LIMIT_MS)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .otg_en      (otg_en),
      .start       (start),
      .init_ok     (init_ok),
      .disch_en    (disch_en),
      .bsess_valid (bsess_valid),
      .vbus_irq    (vbus_irq),
      .tick        (tick),
      .restart     (restart),
      .dp_on       (dp_pulse),
      .vp_on       (vbus_pulse),
      .dis_on      (vbus_disch),
      .done_q      (done_q),
      .ok_q        (ok_q),
      .fail_q      (fail_q)
   );

   assign done = done_q && otg_en;
   assign ok   = ok_q   && otg_en;
   assign fail = fail_q && otg_en;

   assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok != fail));

   assert_mask_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(otg_en) |-> !(dp_pulse || vbus_pulse || vbus_disch || done));

endmodule

// File: tb/test_srp_sequencer.sv
`timescale 1ns/1ps

module srp_ref_model #(
   parameter int DIV = 8,
   parameter int DP  = 7,
   parameter int VP  = 20,
   parameter int DIS = 30,
   parameter int DET = 40,
   parameter int LIM = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       start,
   input  logic       init_ok,
   input  logic       dis_en,
   input  logic       bsess,
   output logic [5:0] outs
);
   int   ph, cyc, tot;
   logic d, o, f;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0; cyc = 0; tot = 0; d = 0; o = 0; f = 0;
      end else begin
         d = 0; o = 0; f = 0;
         if (!en) begin
            ph = 0; cyc = 0; tot = 0;
         end else if (ph == 0) begin
            if (start) begin
               if (init_ok) begin ph = 1; cyc = 0; tot = 0; end
               else begin d = 1; f = 1; end
            end
         end else if (ph == 1 || ph == 2) begin
            if (cyc == ((ph == 1) ? DP : VP) * DIV - 1) begin
               ph = (ph == 1) ? 2 : (dis_en ? 3 : 4);
               cyc = 0; tot = tot + 1;
            end else if (tot == LIM * DIV - 1) begin
               ph = 0; d = 1; f = 1;
            end else begin
               cyc = cyc + 1; tot = tot + 1;
            end
         end else if (ph == 3) begin
            if (cyc == DIS * DIV - 1) begin ph = 4; cyc = 0; end
            else cyc = cyc + 1;
         end else begin
            if (bsess) begin ph = 0; d = 1; o = 1; end
            else if (cyc == DET * DIV - 1) begin ph = 0; d = 1; f = 1; end
            else cyc = cyc + 1;
         end
      end
   end

   assign outs = {en && ph == 1, en && ph == 2, en && ph == 3, d && en, o && en, f && en};
endmodule

module test_srp_sequencer;
   localparam int CLK_HZ = 8000;
   localparam int DIV = CLK_HZ / 1000;
   localparam int DP = 7, VP = 20, DIS = 30, DET = 40;

   logic clk = 0, rst_n = 0;
   logic otg_en = 0, start = 0, init_ok = 0, disch_en = 0, bsess_valid = 0, vbus_irq = 0;
   logic [5:0] dut_a, dut_b, dut_c, ref_a, ref_b, ref_c;
   int total = 0, bad = 0, cycles = 0, run_cyc = 0;
   int n_dp, n_vp, n_dis, a_at, c_at;
   bit got_a, a_ok, a_fail, got_b, b_ok, got_c, c_fail;

   always #5 clk = ~clk;

   srp_sequencer #(.CLK_HZ(CLK_HZ), .DP_MS(DP), .VP_MS(VP), .DIS_MS(DIS), .DET_MS(DET),
                   .LIMIT_MS(100)) i_srp_sequencer (
      .clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start(start), .init_ok(init_ok),
      .disch_en(disch_en), .bsess_valid(bsess_valid), .vbus_irq(vbus_irq),
      .dp_pulse(dut_a[5]), .vbus_pulse(dut_a[4]), .vbus_disch(dut_a[3]),
      .done(dut_a[2]), .ok(dut_a[1]), .fail(dut_a[0]));

   srp_sequencer #(.CLK_HZ(CLK_HZ), .DP_MS(DP), .VP_MS(VP), .DIS_MS(DIS), .DET_MS(DET),
                   .LIMIT_MS(DP + VP)) i_srp_sequencer_tie (
      .clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start(start), .init_ok(init_ok),
      .disch_en(disch_en), .bsess_valid(bsess_valid), .vbus_irq(vbus_irq),
      .dp_pulse(dut_b[5]), .vbus_pulse(dut_b[4]), .vbus_disch(dut_b[3]),
      .done(dut_b[2]), .ok(dut_b[1]), .fail(dut_b[0]));

   srp_sequencer #(.CLK_HZ(CLK_HZ), .DP_MS(DP), .VP_MS(VP), .DIS_MS(DIS), .DET_MS(DET),
                   .LIMIT_MS(15)) i_srp_sequencer_short (
      .clk(clk), .rst_n(rst_n), .otg_en(otg_en), .start(start), .init_ok(init_ok),
      .disch_en(disch_en), .bsess_valid(bsess_valid), .vbus_irq(vbus_irq),
      .dp_pulse(dut_c[5]), .vbus_pulse(dut_c[4]), .vbus_disch(dut_c[3]),
      .done(dut_c[2]), .ok(dut_c[1]), .fail(dut_c[0]));

   srp_ref_model #(.DIV(DIV), .DP(DP), .VP(VP), .DIS(DIS), .DET(DET), .LIM(100)) m_a (
      .clk(clk), .rst_n(rst_n), .en(otg_en), .start(start), .init_ok(init_ok),
      .dis_en(disch_en), .bsess(bsess_valid), .outs(ref_a));
   srp_ref_model #(.DIV(DIV), .DP(DP), .VP(VP), .DIS(DIS), .DET(DET), .LIM(DP + VP)) m_b (
      .clk(clk), .rst_n(rst_n), .en(otg_en), .start(start), .init_ok(init_ok),
      .dis_en(disch_en), .bsess(bsess_valid), .outs(ref_b));
   srp_ref_model #(.DIV(DIV), .DP(DP), .VP(VP), .DIS(DIS), .DET(DET), .LIM(15)) m_c (
      .clk(clk), .rst_n(rst_n), .en(otg_en), .start(start), .init_ok(init_ok),
      .dis_en(disch_en), .bsess(bsess_valid), .outs(ref_c));

   task automatic check(input bit pass, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!pass) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [5:0] diff);
      if (diff[5]) return "R2";
      if (diff[4]) return "R3";
      if (diff[3]) return "R5";
      return "R7";
   endfunction

   // per-cycle comparison against the reference models
   always @(negedge clk) begin
      if (rst_n) begin
         check(dut_a == ref_a, req_of(dut_a ^ ref_a), "cycle compare main", dut_a, ref_a);
         check(dut_b == ref_b, req_of(dut_b ^ ref_b), "cycle compare tie (R4)", dut_b, ref_b);
         check(dut_c == ref_c, req_of(dut_c ^ ref_c), "cycle compare short (R4)", dut_c, ref_c);
      end
   end

   // run monitor
   always @(negedge clk) begin
      cycles++;
      run_cyc++;
      if (dut_a[5]) n_dp++;
      if (dut_a[4]) n_vp++;
      if (dut_a[3]) n_dis++;
      if (dut_a[2] && !got_a) begin got_a = 1; a_ok = dut_a[1]; a_fail = dut_a[0]; a_at = run_cyc; end
      if (dut_b[2] && !got_b) begin got_b = 1; b_ok = dut_b[1]; end
      if (dut_c[2] && !got_c) begin got_c = 1; c_fail = dut_c[0]; c_at = run_cyc; end
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic begin_run(input logic ini, input logic dis, input logic bs, input logic irq);
      @(posedge clk); #2;
      init_ok = ini; disch_en = dis; bsess_valid = bs; vbus_irq = irq;
      n_dp = 0; n_vp = 0; n_dis = 0; run_cyc = 0;
      got_a = 0; got_b = 0; got_c = 0; a_ok = 0; a_fail = 0; b_ok = 0; c_fail = 0;
      a_at = 0; c_at = 0;
      start = 1;
      @(posedge clk); #2;
      start = 0;
   endtask

   task automatic wait_a();
      for (int i = 0; i < 3000 && !got_a; i++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1; otg_en = 1;
      @(negedge clk);
      check(dut_a == 6'd0, "R9", "reset outputs", dut_a, 0);

      // R1: start without initial condition
      begin_run(0, 0, 0, 0);
      wait_a();
      check(got_a && a_fail && !a_ok, "R1", "refused start gives fail", a_fail, 1);
      check(a_at == 2, "R1", "refused result cycle", a_at, 2);
      check(n_dp == 0, "R1", "no D+ pulse when refused", n_dp, 0);

      // main run: vbus_irq held high (R8), bsess high during pulsing (R6)
      begin_run(1, 0, 1, 1);
      wait_a();
      check(n_dp == DP * DIV, "R2", "D+ pulse length", n_dp, DP * DIV);
      check(n_vp == VP * DIV, "R3", "VBUS pulse length", n_vp, VP * DIV);
      check(n_dis == 0, "R5", "no discharge when disabled", n_dis, 0);
      check(a_ok && !a_fail, "R6", "session success", a_ok, 1);
      check(a_at == 2 + (DP + VP) * DIV + 1, "R6", "success cycle", a_at, 2 + (DP + VP) * DIV + 1);
      check(a_at == 2 + (DP + VP) * DIV + 1, "R8", "irq did not shorten run", a_at, 2 + (DP + VP) * DIV + 1);
      check(got_b && b_ok, "R4", "pulse end on deadline tick wins", b_ok, 1);
      check(got_c && c_fail, "R4", "short deadline fails", c_fail, 1);
      check(c_at == 2 + 15 * DIV, "R4", "deadline cycle", c_at, 2 + 15 * DIV);

      // discharge then detect timeout
      begin_run(1, 1, 0, 0);
      wait_a();
      check(n_dis == DIS * DIV, "R5", "discharge length", n_dis, DIS * DIV);
      check(a_fail && !a_ok, "R7", "detect timeout fails", a_fail, 1);
      check(a_at == 2 + (DP + VP + DIS + DET) * DIV, "R7", "timeout cycle", a_at,
            2 + (DP + VP + DIS + DET) * DIV);

      // abort during VBUS pulse
      begin_run(1, 0, 0, 0);
      for (int i = 0; i < 1000 && !dut_a[4]; i++) @(negedge clk);
      @(posedge clk); #2 otg_en = 0;
      @(negedge clk);
      check(dut_a == 6'd0, "R9", "outputs low in abort cycle", dut_a, 0);
      @(posedge clk); #2 otg_en = 1;
      n_dp = 0; n_vp = 0; got_a = 0;
      repeat (40) @(negedge clk);
      check(n_dp == 0 && n_vp == 0 && !got_a, "R9", "no resume after re-enable", n_dp + n_vp, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule